// File: doc/BRIEF.md
# Extended Accumulator Datapath

This block holds two 32-bit accumulators, A and B, each paired with a 4-bit extension register that has its own address. Every cycle in which the operation strobe is high, the block applies one operation. The operation takes the selected register and a 32-bit memory operand. The operations are bitwise logic, load, add, subtract, reverse subtract, and shifts by a fixed amount of 1 to 4. The shifts read either the register or the operand.

Add, subtract and reverse subtract treat an accumulator and its extension as one 36-bit number. They sign-extend the operand to 36 bits, and the result is split back: the low 32 bits go to the accumulator and the top 4 bits go to the extension. All other operations treat the accumulator and the extension as independent registers. The extension can also be the destination of an operation, and it then acts as a plain 4-bit register.

A direct write port and a combinational read port give access to all four registers. They are used to preload values and to observe results.

Top module: `ext_acc_top`

## Requirements
- R1: A synchronous reset with `rst` high clears both accumulators and both extension registers to zero.
- R2: When `op_valid` and `wr_en` are both low, no register changes. Opcodes 0 and 14 to 15 change nothing even when `op_valid` is high.
- R3: Opcodes 1 (AND), 2 (OR) and 3 (XOR) with an accumulator destination combine the accumulator with the operand bitwise. The paired extension is left unchanged.
- R4: Opcode 4 (ADD) with an accumulator destination forms {ext, acc} + sign-extended operand over 36 bits. The low 32 bits of the result go to the accumulator and the high 4 bits go to the extension.
- R5: Opcode 5 (SUB) forms {ext, acc} minus the sign-extended operand and splits the result as in R4.
- R6: Opcode 6 (RSUB) forms the sign-extended operand minus {ext, acc} and splits the result as in R4.
- R7: Opcode 7 (LOAD) copies the operand into the accumulator and leaves the extension unchanged.
- R8: Opcodes 8 (shift left logical), 9 (shift right logical) and 10 (shift right arithmetic, sign taken from bit 31) shift the accumulator by `op_shamt`+1 places. The extension is left unchanged.
- R9: Opcodes 11, 12 and 13 perform the same three shifts on the operand instead of the accumulator and write the result to the accumulator. The old accumulator value has no effect on the result.
- R10: A destination code of 2 or 3 makes the extension the target of the operation. The extension then acts as a plain 4-bit register: it uses operand bits [3:0], arithmetic wraps modulo 16, and the paired accumulator is left unchanged.
- R11: `rd_data` returns the register chosen by `rd_sel`: 0 selects acc A, 1 acc B, 2 ext A, 3 ext B. An extension reads back zero-extended to 32 bits.
- R12: `wr_en` writes `wr_data` to the register chosen by `wr_sel`, which uses the same codes as R11. An extension keeps only bits [3:0]. When the write port and an operation target the same register in the same cycle, the write port wins.
- R13: An operation never changes the pair it does not address. Destination codes are 0 for acc A, 1 for acc B, 2 for ext A and 3 for ext B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe that applies the operation this cycle |
| op_code | input | 4 | Operation code |
| op_dest | input | 2 | Destination register code |
| op_shamt | input | 2 | Shift amount minus one |
| op_operand | input | 32 | Memory operand |
| wr_en | input | 1 | Direct register write enable |
| wr_sel | input | 2 | Direct write register code |
| wr_data | input | 32 | Direct write data |
| rd_sel | input | 2 | Read register code |
| rd_data | output | 32 | Selected register value, extensions zero-extended |

## Verification
The checker watches every cycle for the following: the reset clearing all registers, registers holding still when nothing is strobed, the pair that is not addressed staying untouched, and the 36-bit add split into both registers. It also checks that extensions survive the non-arithmetic operations, that the write port takes priority, and that extensions read back zero-extended. Other behaviour only shows in the bench's directed scenarios with hand-computed values. This covers borrow and carry crossing into the extension on subtract and reverse subtract, the exact results of each shift kind and amount, shifts that ignore the old accumulator, and modulo-16 arithmetic on an extension destination.

// File: rtl/ext_acc_pkg.sv
package ext_acc_pkg;

    localparam int ACC_W  = 32;
    localparam int EXT_W  = 4;
    localparam int WIDE_W = ACC_W + EXT_W;
    localparam int NPAIR  = 2;
    localparam int AMT_W  = 3;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_AND   = 4'd1,
        OP_OR    = 4'd2,
        OP_XOR   = 4'd3,
        OP_ADD   = 4'd4,
        OP_SUB   = 4'd5,
        OP_RSUB  = 4'd6,
        OP_LOAD  = 4'd7,
        OP_SLL_R = 4'd8,
        OP_SRL_R = 4'd9,
        OP_SRA_R = 4'd10,
        OP_SLL_M = 4'd11,
        OP_SRL_M = 4'd12,
        OP_SRA_M = 4'd13
    } op_e;

    // register code: bit 1 selects the extension, bit 0 the pair
    typedef struct packed {
        logic is_ext;
        logic pair;
    } sel_t;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [EXT_W-1:0] ext;
        logic             acc_we;
        logic             ext_we;
    } wide_res_t;

    typedef struct packed {
        logic [EXT_W-1:0] val;
        logic             we;
    } narrow_res_t;

    function automatic logic [WIDE_W-1:0] sext_operand(input logic [ACC_W-1:0] v);
        return {{EXT_W{v[ACC_W-1]}}, v};
    endfunction

    function automatic logic [AMT_W-1:0] shift_amount(input logic [1:0] code);
        return {1'b0, code} + AMT_W'(1);
    endfunction

    function automatic logic from_operand(input op_e op);
        return (op == OP_SLL_M) || (op == OP_SRL_M) || (op == OP_SRA_M);
    endfunction

endpackage

// File: rtl/ext_acc_wide_alu.sv
module ext_acc_wide_alu
    import ext_acc_pkg::*;
(
    input  op_e              op,
    input  logic [1:0]       shamt,
    input  logic [ACC_W-1:0] acc,
    input  logic [EXT_W-1:0] ext,
    input  logic [ACC_W-1:0] opnd,
    output wide_res_t        res
);
    logic [WIDE_W-1:0] joined;
    logic [WIDE_W-1:0] opx;
    logic [WIDE_W-1:0] sum;
    logic [WIDE_W-1:0] dif;
    logic [WIDE_W-1:0] rdif;
    logic [ACC_W-1:0]  sh_src;
    logic [AMT_W-1:0]  amt;

    always_comb begin
        joined = {ext, acc};
        opx    = sext_operand(opnd);
        sum    = joined + opx;
        dif    = joined - opx;
        rdif   = opx - joined;
        amt    = shift_amount(shamt);
        sh_src = from_operand(op) ? opnd : acc;

        res        = '0;
        res.acc    = acc;
        res.ext    = ext;
        case (op)
            OP_AND:  begin res.acc = acc & opnd; res.acc_we = 1'b1; end
            OP_OR:   begin res.acc = acc | opnd; res.acc_we = 1'b1; end
            OP_XOR:  begin res.acc = acc ^ opnd; res.acc_we = 1'b1; end
            OP_LOAD: begin res.acc = opnd;       res.acc_we = 1'b1; end
            OP_ADD: begin
                res.acc = sum[ACC_W-1:0];
                res.ext = sum[WIDE_W-1:ACC_W];
                res.acc_we = 1'b1;
                res.ext_we = 1'b1;
            end
            OP_SUB: begin
                res.acc = dif[ACC_W-1:0];
                res.ext = dif[WIDE_W-1:ACC_W];
                res.acc_we = 1'b1;
                res.ext_we = 1'b1;
            end
            OP_RSUB: begin
                res.acc = rdif[ACC_W-1:0];
                res.ext = rdif[WIDE_W-1:ACC_W];
                res.acc_we = 1'b1;
                res.ext_we = 1'b1;
            end
            OP_SLL_R, OP_SLL_M: begin
                res.acc = sh_src << amt;
                res.acc_we = 1'b1;
            end
            OP_SRL_R, OP_SRL_M: begin
                res.acc = sh_src >> amt;
                res.acc_we = 1'b1;
            end
            OP_SRA_R, OP_SRA_M: begin
                res.acc = ACC_W'($signed(sh_src) >>> amt);
                res.acc_we = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ext_acc_narrow_alu.sv
module ext_acc_narrow_alu
    import ext_acc_pkg::*;
(
    input  op_e              op,
    input  logic [1:0]       shamt,
    input  logic [EXT_W-1:0] ext,
    input  logic [ACC_W-1:0] opnd,
    output narrow_res_t      res
);
    logic [EXT_W-1:0] lo;
    logic [EXT_W-1:0] sh_src;
    logic [AMT_W-1:0] amt;

    always_comb begin
        lo     = opnd[EXT_W-1:0];
        amt    = shift_amount(shamt);
        sh_src = from_operand(op) ? lo : ext;
        res    = '0;
        res.val = ext;
        res.we  = 1'b1;
        case (op)
            OP_AND:   res.val = ext & lo;
            OP_OR:    res.val = ext | lo;
            OP_XOR:   res.val = ext ^ lo;
            OP_LOAD:  res.val = lo;
            OP_ADD:   res.val = ext + lo;
            OP_SUB:   res.val = ext - lo;
            OP_RSUB:  res.val = lo - ext;
            OP_SLL_R, OP_SLL_M: res.val = sh_src << amt;
            OP_SRL_R, OP_SRL_M: res.val = sh_src >> amt;
            OP_SRA_R, OP_SRA_M: res.val = EXT_W'($signed(sh_src) >>> amt);
            default:  res.we = 1'b0;
        endcase
    end
endmodule

// File: rtl/ext_acc_regs.sv
module ext_acc_regs
    import ext_acc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        op_fire,
    input  sel_t                        dest,
    input  wide_res_t                   wres,
    input  narrow_res_t                 nres,
    input  logic                        wr_en,
    input  sel_t                        wr_sel,
    input  logic [ACC_W-1:0]            wr_data,
    output logic [NPAIR-1:0][ACC_W-1:0] acc_q,
    output logic [NPAIR-1:0][EXT_W-1:0] ext_q
);
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic hit;
        logic wr_acc;
        logic wr_ext;

        always_comb begin
            hit    = op_fire && (dest.pair == 1'(p));
            wr_acc = wr_en && !wr_sel.is_ext && (wr_sel.pair == 1'(p));
            wr_ext = wr_en &&  wr_sel.is_ext && (wr_sel.pair == 1'(p));
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                acc_q[p] <= '0;
            end else if (wr_acc) begin
                acc_q[p] <= wr_data;
            end else if (hit && !dest.is_ext && wres.acc_we) begin
                acc_q[p] <= wres.acc;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ext_q[p] <= '0;
            end else if (wr_ext) begin
                ext_q[p] <= wr_data[EXT_W-1:0];
            end else if (hit && dest.is_ext && nres.we) begin
                ext_q[p] <= nres.val;
            end else if (hit && !dest.is_ext && wres.ext_we) begin
                ext_q[p] <= wres.ext;
            end
        end
    end
endmodule

// File: rtl/ext_acc_top.sv
module ext_acc_top
    import ext_acc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        op_valid,
    input  logic [3:0]  op_code,
    input  logic [1:0]  op_dest,
    input  logic [1:0]  op_shamt,
    input  logic [31:0] op_operand,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [31:0] wr_data,
    input  logic [1:0]  rd_sel,
    output logic [31:0] rd_data
);
    logic [NPAIR-1:0][ACC_W-1:0] acc_q;
    logic [NPAIR-1:0][EXT_W-1:0] ext_q;
    op_e         op;
    sel_t        dsel;
    sel_t        wsel;
    sel_t        rsel;
    wide_res_t   wres;
    narrow_res_t nres;
    logic [ACC_W-1:0] cur_acc;
    logic [EXT_W-1:0] cur_ext;

    always_comb begin
        op      = op_e'(op_code);
        dsel    = sel_t'(op_dest);
        wsel    = sel_t'(wr_sel);
        rsel    = sel_t'(rd_sel);
        cur_acc = acc_q[dsel.pair];
        cur_ext = ext_q[dsel.pair];
    end

    ext_acc_wide_alu u_wide (
        .op    (op),
        .shamt (op_shamt),
        .acc   (cur_acc),
        .ext   (cur_ext),
        .opnd  (op_operand),
        .res   (wres)
    );

    ext_acc_narrow_alu u_narrow (
        .op    (op),
        .shamt (op_shamt),
        .ext   (cur_ext),
        .opnd  (op_operand),
        .res   (nres)
    );

    ext_acc_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .op_fire (op_valid),
        .dest    (dsel),
        .wres    (wres),
        .nres    (nres),
        .wr_en   (wr_en),
        .wr_sel  (wsel),
        .wr_data (wr_data),
        .acc_q   (acc_q),
        .ext_q   (ext_q)
    );

    always_comb begin
        if (rsel.is_ext) begin
            rd_data = {{(ACC_W-EXT_W){1'b0}}, ext_q[rsel.pair]};
        end else begin
            rd_data = acc_q[rsel.pair];
        end
    end
endmodule

// File: rtl/ext_acc_chk.sv
module ext_acc_chk
    import ext_acc_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic                        op_valid,
    input logic [3:0]                  op_code,
    input logic [1:0]                  op_dest,
    input logic [31:0]                 op_operand,
    input logic                        wr_en,
    input logic [1:0]                  wr_sel,
    input logic [31:0]                 wr_data,
    input logic [1:0]                  rd_sel,
    input logic [31:0]                 rd_data,
    input logic [NPAIR-1:0][ACC_W-1:0] acc_q,
    input logic [NPAIR-1:0][EXT_W-1:0] ext_q
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (acc_q == '0) && (ext_q == '0)); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!op_valid && !wr_en) |=> $stable(acc_q) && $stable(ext_q)); // R2

    AST_EXT_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_sel[1] |-> (rd_data[31:EXT_W] == '0)); // R11

    for (genvar p = 0; p < NPAIR; p++) begin : g_chk
        AST_ADD_SPLIT: assert property (@(posedge clk) disable iff (rst)
            (op_valid && !wr_en && op_code == 4'd4 && op_dest == {1'b0, 1'(p)})
            |=> ({ext_q[p], acc_q[p]} ==
                 $past({ext_q[p], acc_q[p]}) + $past({{EXT_W{op_operand[31]}}, op_operand}))); // R4

        AST_EXT_KEEP: assert property (@(posedge clk) disable iff (rst)
            (op_valid && !wr_en && op_dest == {1'b0, 1'(p)} &&
             op_code != 4'd4 && op_code != 4'd5 && op_code != 4'd6)
            |=> $stable(ext_q[p])); // R3

        AST_OTHER_PAIR: assert property (@(posedge clk) disable iff (rst)
            (op_valid && !wr_en && op_dest[0] != 1'(p))
            |=> $stable(acc_q[p]) && $stable(ext_q[p])); // R13

        AST_WRITE_ACC_WINS: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == {1'b0, 1'(p)}) |=> (acc_q[p] == $past(wr_data))); // R12

        AST_WRITE_EXT_WINS: assert property (@(posedge clk) disable iff (rst)
            (wr_en && wr_sel == {1'b1, 1'(p)}) |=> (ext_q[p] == $past(wr_data[EXT_W-1:0]))); // R12
    end
endmodule

bind ext_acc_top ext_acc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .op_dest    (op_dest),
    .op_operand (op_operand),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .acc_q      (acc_q),
    .ext_q      (ext_q)
);

// File: tb/ext_acc_top_bench.sv
`timescale 1ns/1ps
module ext_acc_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [1:0]  op_dest = '0;
    logic [1:0]  op_shamt = '0;
    logic [31:0] op_operand = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = '0;
    logic [31:0] rd_data;
    int total = 0;
    int bad = 0;

    localparam logic [1:0] AA = 2'd0, AB = 2'd1, EA = 2'd2, EB = 2'd3;

    always #2.5 clk = ~clk;

    ext_acc_top u_ext_acc_top (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_dest(op_dest), .op_shamt(op_shamt), .op_operand(op_operand),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [1:0] sel, input logic [31:0] exp);
        rd_sel = sel;
        #1;
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s reg=%0d actual=%h expected=%h", req, sel, rd_data, exp);
        end
    endtask

    task automatic put(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input logic [3:0] code, input logic [1:0] dest,
                       input logic [1:0] sh, input logic [31:0] opnd, input logic vld);
        @(negedge clk);
        op_valid = vld; op_code = code; op_dest = dest; op_shamt = sh; op_operand = opnd;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R1", AA, 32'h0); check("R1", AB, 32'h0);
        check("R1", EA, 32'h0); check("R1", EB, 32'h0);
    endtask

    task automatic t_logic;
        put(AA, 32'hF0F0_1234); put(EA, 32'h5);
        run(4'd1, AA, 2'd0, 32'hFF00_FF00, 1'b1);
        check("R3", AA, 32'hF000_1200);
        check("R3", EA, 32'h5);
        run(4'd2, AA, 2'd0, 32'h0000_000F, 1'b1);
        check("R3", AA, 32'hF000_120F);
        run(4'd3, AA, 2'd0, 32'hFFFF_FFFF, 1'b1);
        check("R3", AA, 32'h0FFF_EDF0);
        check("R3", EA, 32'h5);
    endtask

    task automatic t_add;
        put(AA, 32'hFFFF_FFFF); put(EA, 32'h0);
        run(4'd4, AA, 2'd0, 32'h1, 1'b1);
        check("R4", AA, 32'h0); check("R4", EA, 32'h1);
        run(4'd4, AA, 2'd0, 32'hFFFF_FFFF, 1'b1);
        check("R4", AA, 32'hFFFF_FFFF); check("R4", EA, 32'h0);
        run(4'd4, AA, 2'd0, 32'hFFFF_FFFF, 1'b1);
        check("R4", AA, 32'hFFFF_FFFE); check("R4", EA, 32'h0);
    endtask

    task automatic t_sub;
        put(AA, 32'h0); put(EA, 32'h0);
        run(4'd5, AA, 2'd0, 32'h1, 1'b1);
        check("R5", AA, 32'hFFFF_FFFF); check("R5", EA, 32'hF);
        run(4'd5, AA, 2'd0, 32'h8000_0000, 1'b1);
        check("R5", AA, 32'h7FFF_FFFF); check("R5", EA, 32'h0);
    endtask

    task automatic t_rsub;
        put(AA, 32'h1111_1111); put(EA, 32'h2);
        put(AB, 32'h5); put(EB, 32'h0);
        run(4'd6, AB, 2'd0, 32'h3, 1'b1);
        check("R6", AB, 32'hFFFF_FFFE); check("R6", EB, 32'hF);
        check("R13", AA, 32'h1111_1111); check("R13", EA, 32'h2);
    endtask

    task automatic t_load;
        put(EA, 32'h7);
        run(4'd7, AA, 2'd0, 32'hDEAD_BEEF, 1'b1);
        check("R7", AA, 32'hDEAD_BEEF); check("R7", EA, 32'h7);
    endtask

    task automatic t_shift_reg;
        put(EA, 32'h3);
        put(AA, 32'h8000_0011);
        run(4'd10, AA, 2'd3, 32'h0, 1'b1);
        check("R8", AA, 32'hF800_0001); check("R8", EA, 32'h3);
        put(AA, 32'h8000_0011);
        run(4'd9, AA, 2'd0, 32'h0, 1'b1);
        check("R8", AA, 32'h4000_0008);
        put(AA, 32'h8000_0011);
        run(4'd8, AA, 2'd1, 32'h0, 1'b1);
        check("R8", AA, 32'h0000_0044);
    endtask

    task automatic t_shift_mem;
        put(AA, 32'h1234_5678);
        run(4'd11, AA, 2'd2, 32'h1000_0001, 1'b1);
        check("R9", AA, 32'h8000_0008);
        run(4'd13, AA, 2'd0, 32'h8000_0000, 1'b1);
        check("R9", AA, 32'hC000_0000);
        run(4'd12, AA, 2'd3, 32'h0000_00F0, 1'b1);
        check("R9", AA, 32'h0000_000F);
    endtask

    task automatic t_ext_dest;
        put(AA, 32'hCAFE_0001); put(EA, 32'hE);
        run(4'd4, EA, 2'd0, 32'h0000_0005, 1'b1);
        check("R10", EA, 32'h3); check("R10", AA, 32'hCAFE_0001);
        put(EB, 32'hF);
        run(4'd1, EB, 2'd0, 32'hFFFF_FFF6, 1'b1);
        check("R10", EB, 32'h6);
    endtask

    task automatic t_ports;
        put(EA, 32'hFFFF_FFFA);
        check("R11", EA, 32'h0000_000A);
        put(AB, 32'h0BAD_F00D);
        check("R12", AB, 32'h0BAD_F00D);
        @(negedge clk);
        op_valid = 1'b1; op_code = 4'd4; op_dest = AB; op_operand = 32'h1;
        wr_en = 1'b1; wr_sel = AB; wr_data = 32'h1234_ABCD;
        @(negedge clk);
        op_valid = 1'b0; wr_en = 1'b0;
        check("R12", AB, 32'h1234_ABCD);
    endtask

    task automatic t_idle;
        put(AA, 32'h5555_AAAA); put(EA, 32'h9);
        run(4'd4, AA, 2'd0, 32'h1, 1'b0);
        check("R2", AA, 32'h5555_AAAA); check("R2", EA, 32'h9);
        run(4'd14, AA, 2'd0, 32'h1, 1'b1);
        check("R2", AA, 32'h5555_AAAA); check("R2", EA, 32'h9);
        run(4'd0, EA, 2'd0, 32'h1, 1'b1);
        check("R2", EA, 32'h9);
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        t_reset();
    endtask

    initial begin
        #(200000.0 * 5.0);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_logic();
        t_add();
        t_sub();
        t_rsub();
        t_load();
        t_shift_reg();
        t_shift_mem();
        t_ext_dest();
        t_ports();
        t_idle();
        t_reset_again();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule